// File: doc/BRIEF.md
# Dual-Mode Coefficient Load Controller

This block fills the tap-coefficient store and the 16-bit configuration register of a filter engine. It runs in one of two modes, fixed by a mode pin while the block is held in reset. In host mode an external controller acts as a bus master. It presents an address, a target select line, data, an active-low chip select and an active-low write enable, and coefficients go in one at a time. In self-load mode the block is the master. It sweeps an 8-bit address across a byte-wide external memory on its own, drives an active-low strobe so that slave devices can capture the same bytes, and raises busy until the whole set has been stored.

Coefficients are 16 bits wide. They are written either as a single word or as a low/high byte pair. Bit 6 of the 7-bit coefficient index picks the lower or upper bank. A swap input chooses which bank the filter's read address points into, so one bank can be rewritten while the other is in use.

The controller has five states:
- `ST_HOLD`: reset, or the first cycle after it.
- `ST_COEF`: sweeps the coefficient bytes.
- `ST_CTRL`: reads the two configuration-register bytes.
- `ST_HOST`: serves the host bus.
- `ST_DONE`: self-load has finished.

It has four transitions:
- `ST_HOLD` goes to `ST_COEF` on the first edge after reset when the mode pin is high, and to `ST_HOST` when it is low.
- `ST_COEF` goes to `ST_CTRL` after address 255.
- `ST_CTRL` goes to `ST_DONE` after its second byte.
- `ST_HOST` and `ST_DONE` are final until the next reset.

Top module: `coef_loader`

## Requirements
- R1: While `rst_n` is low, `strobe_n` is 1, `coef_we` is 0 and `ctrl_q` is 0. In that time `busy` equals `self_load`.
- R2: In host mode a write happens only on an edge where `host_cs_n` and `host_we_n` are both 0. If either is 1, the edge produces no `coef_we` pulse and leaves `ctrl_q` unchanged.
- R3: Host word mode is selected with `word_mode`=1. A write with `reg_sel`=0 stores `data_in[15:0]` at coefficient index `addr_in[6:0]`, and `addr_in[7]` has no effect.
- R4: Host byte mode is selected with `word_mode`=0. A write to an even address (bit 0 = 0) only latches `data_in[7:0]` as the low byte and produces no store. A following write to an odd address stores {`data_in[7:0]`, latched low byte} at index `addr_in[7:1]`.
- R5: With `reg_sel`=1 a write goes to the configuration register `ctrl_q` and produces no `coef_we` pulse. It uses the same word/byte packing as R3 and R4.
- R6: In self-load mode the sweep begins on the first edge after `rst_n` rises. The block first steps `mem_addr` through 0..255 with `mem_sel`=0, then through 0..1 with `mem_sel`=1, one byte per cycle. `busy` is 1 from reset through the last configuration byte, which makes 259 cycles after release, and then falls.
- R7: In self-load mode every memory byte comes from `data_in[7:0]` and is packed low byte first, whatever `word_mode` is. Host-bus inputs have no effect.
- R8: `strobe_n` is 0 in exactly the 258 byte cycles of a self-load sweep and 1 at all other times.
- R9: `coef_raddr` equals {`bank_swap`, `rd_tap`}, so `bank_swap`=0 reads the lower bank (index bit 6 = 0) and 1 reads the upper bank.
- R10: A store drives `coef_we` high for exactly one cycle, starting right after the committing edge, with `coef_waddr`/`coef_wdata` valid during it. `ctrl_q` takes its new value at the committing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts self-load |
| self_load | input | 1 | 1 = self-load from byte memory, 0 = host mode |
| word_mode | input | 1 | Host packing: 1 = 16-bit words, 0 = byte pairs |
| addr_in | input | 8 | Host address |
| reg_sel | input | 1 | Host target: 0 = coefficients, 1 = configuration register |
| data_in | input | 16 | Host data, or memory byte on bits 7:0 |
| host_cs_n | input | 1 | Host chip select, active low |
| host_we_n | input | 1 | Host write enable, active low |
| bank_swap | input | 1 | Read bank select: 0 lower, 1 upper |
| rd_tap | input | 6 | Tap index within the read bank |
| mem_addr | output | 8 | Memory address during self-load |
| mem_sel | output | 1 | Memory high address: 1 during configuration bytes |
| strobe_n | output | 1 | Active-low write strobe for slave devices |
| busy | output | 1 | Self-load in progress |
| coef_we | output | 1 | Coefficient store write enable |
| coef_waddr | output | 7 | Coefficient write index (bit 6 = bank) |
| coef_wdata | output | 16 | Coefficient write data |
| coef_raddr | output | 7 | Coefficient read index for the filter |
| ctrl_q | output | 16 | Configuration register |

## Verification
Each store shows up on `coef_we`/`coef_waddr`/`coef_wdata` one edge after the edge that commits it. The bench therefore drives each vector at a falling edge, lets one rising edge pass, and compares at the next falling edge, where it also confirms that an even-byte write or a gated write left both outputs idle. `ctrl_q`, `busy`, `strobe_n` and `mem_addr` change at the same edge as the state they reflect. During self-load they are sampled at every falling edge from the release of reset onward: `busy` is expected high for 259 samples and `strobe_n` low for 258, and the 128 store pulses are expected in index order. `coef_raddr` is combinational and is compared a short settle delay after its inputs change.

// File: rtl/coef_load_pkg.sv
package coef_load_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_COEF,
        ST_CTRL,
        ST_HOST,
        ST_DONE
    } load_state_t;

    // bytes making up the configuration register in the self-load stream
    localparam int CTRL_BYTES = 2;

endpackage

// File: rtl/coef_load_seq.sv
module coef_load_seq
    import coef_load_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              self_load,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel,
    output logic              busy,
    output logic              strobe_n,
    output logic              auto_wr,
    output logic              host_en
);

    localparam logic [ADDR_W-1:0] COEF_LAST = '1;
    localparam logic [ADDR_W-1:0] CTRL_LAST = ADDR_W'(CTRL_BYTES - 1);

    load_state_t       state, nxt;
    logic [ADDR_W-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD: nxt = self_load ? ST_COEF : ST_HOST;
            ST_COEF: if (cnt == COEF_LAST) nxt = ST_CTRL;
            ST_CTRL: if (cnt == CTRL_LAST) nxt = ST_DONE;
            ST_HOST: nxt = ST_HOST;
            ST_DONE: nxt = ST_DONE;
            default: nxt = ST_HOLD;
        endcase
    end

    // byte counter, restarts when the sweep moves to a new target
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (state)
                ST_COEF: cnt <= (cnt == COEF_LAST) ? '0 : cnt + ADDR_W'(1);
                ST_CTRL: cnt <= (cnt == CTRL_LAST) ? '0 : cnt + ADDR_W'(1);
                default: cnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_addr = cnt;
        mem_sel  = 1'b0;
        busy     = 1'b0;
        strobe_n = 1'b1;
        auto_wr  = 1'b0;
        host_en  = 1'b0;
        unique case (state)
            ST_HOLD: busy = self_load;
            ST_COEF: begin
                busy     = 1'b1;
                strobe_n = 1'b0;
                auto_wr  = 1'b1;
            end
            ST_CTRL: begin
                busy     = 1'b1;
                strobe_n = 1'b0;
                auto_wr  = 1'b1;
                mem_sel  = 1'b1;
            end
            ST_HOST: host_en = 1'b1;
            ST_DONE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/coef_packer.sv
module coef_packer #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              sel,
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] data,
    output logic              coef_we,
    output logic [ADDR_W-2:0] coef_waddr,
    output logic [WORD_W-1:0] coef_wdata,
    output logic [WORD_W-1:0] ctrl_q
);

    localparam int BYTE_W = WORD_W / 2;
    localparam int IDX_W  = ADDR_W - 1;

    logic [BYTE_W-1:0] lo_q;
    logic              commit;
    logic              take_lo;
    logic [WORD_W-1:0] word;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        commit  = req && (!byte_mode || addr[0]);
        take_lo = req && byte_mode && !addr[0];
        word    = byte_mode ? {data[BYTE_W-1:0], lo_q} : data;
        idx     = byte_mode ? addr[ADDR_W-1:1] : addr[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lo_q <= '0;
        else if (take_lo) lo_q <= data[BYTE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coef_we    <= 1'b0;
            coef_waddr <= '0;
            coef_wdata <= '0;
            ctrl_q     <= '0;
        end else begin
            coef_we <= commit && !sel;
            if (commit && !sel) begin
                coef_waddr <= idx;
                coef_wdata <= word;
            end
            if (commit && sel) ctrl_q <= word;
        end
    end

endmodule

// File: rtl/coef_loader.sv
module coef_loader #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              self_load,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] data_in,
    input  logic              host_cs_n,
    input  logic              host_we_n,
    input  logic              bank_swap,
    input  logic [ADDR_W-3:0] rd_tap,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel,
    output logic              strobe_n,
    output logic              busy,
    output logic              coef_we,
    output logic [ADDR_W-2:0] coef_waddr,
    output logic [WORD_W-1:0] coef_wdata,
    output logic [ADDR_W-2:0] coef_raddr,
    output logic [WORD_W-1:0] ctrl_q
);

    logic              auto_wr, host_en;
    logic              w_req, w_sel, w_byte;
    logic [ADDR_W-1:0] w_addr;

    coef_load_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .self_load(self_load),
        .mem_addr (mem_addr),
        .mem_sel  (mem_sel),
        .busy     (busy),
        .strobe_n (strobe_n),
        .auto_wr  (auto_wr),
        .host_en  (host_en)
    );

    // write source select: the sequencer owns the port during self-load
    always_comb begin
        if (auto_wr) begin
            w_req  = 1'b1;
            w_sel  = mem_sel;
            w_byte = 1'b1;
            w_addr = mem_addr;
        end else begin
            w_req  = host_en && !host_cs_n && !host_we_n;
            w_sel  = reg_sel;
            w_byte = !word_mode;
            w_addr = addr_in;
        end
    end

    coef_packer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (w_req),
        .sel       (w_sel),
        .byte_mode (w_byte),
        .addr      (w_addr),
        .data      (data_in),
        .coef_we   (coef_we),
        .coef_waddr(coef_waddr),
        .coef_wdata(coef_wdata),
        .ctrl_q    (ctrl_q)
    );

    assign coef_raddr = {bank_swap, rd_tap};

endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_mode,
    input logic [ADDR_W-1:0] addr_in,
    input logic              host_cs_n,
    input logic              host_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel,
    input logic              strobe_n,
    input logic              busy,
    input logic              coef_we,
    input logic [WORD_W-1:0] ctrl_q
);

    assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (host_cs_n || host_we_n)) |=> (!coef_we && $stable(ctrl_q)));

    assert_even_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !word_mode && !host_cs_n && !host_we_n && !addr_in[0])
        |=> (!coef_we && $stable(ctrl_q)));

    assert_ctrl_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(mem_sel) && $past(mem_addr[0])));

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && !$past(strobe_n) && (mem_sel == $past(mem_sel)))
        |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    assert_strobe_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> busy);

endmodule

bind coef_loader coef_loader_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_mode(word_mode),
    .addr_in  (addr_in),
    .host_cs_n(host_cs_n),
    .host_we_n(host_we_n),
    .mem_addr (mem_addr),
    .mem_sel  (mem_sel),
    .strobe_n (strobe_n),
    .busy     (busy),
    .coef_we  (coef_we),
    .ctrl_q   (ctrl_q)
);

// File: tb/sim_coef_loader.sv
`timescale 1ns/1ps
module sim_coef_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        self_load = 1'b0, word_mode = 1'b1, reg_sel = 1'b0;
    logic [7:0]  addr_in = '0;
    logic [15:0] host_data = '0;
    logic [15:0] data_in;
    logic        host_cs_n = 1'b1, host_we_n = 1'b1, bank_swap = 1'b0;
    logic [5:0]  rd_tap = '0;
    logic [7:0]  mem_addr;
    logic        mem_sel, strobe_n, busy, coef_we;
    logic [6:0]  coef_waddr, coef_raddr;
    logic [15:0] coef_wdata, ctrl_q;
    logic        rom_on = 1'b0;
    logic [7:0]  rom_byte;

    int nchk = 0, nfail = 0, cyc = 0;

    always #2.5 clk = ~clk;

    // byte memory model for self-load; upper data bits are junk on purpose
    assign rom_byte = mem_sel ? (mem_addr[0] ? 8'hA5 : 8'h3C) : (mem_addr ^ 8'h5A);
    assign data_in  = rom_on ? {8'hFF, rom_byte} : host_data;

    coef_loader u0 (
        .clk(clk), .rst_n(rst_n), .self_load(self_load), .word_mode(word_mode),
        .addr_in(addr_in), .reg_sel(reg_sel), .data_in(data_in),
        .host_cs_n(host_cs_n), .host_we_n(host_we_n), .bank_swap(bank_swap),
        .rd_tap(rd_tap), .mem_addr(mem_addr), .mem_sel(mem_sel),
        .strobe_n(strobe_n), .busy(busy), .coef_we(coef_we),
        .coef_waddr(coef_waddr), .coef_wdata(coef_wdata),
        .coef_raddr(coef_raddr), .ctrl_q(ctrl_q)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {wm, sel, cs_n, we_n, addr[8], data[16], exp_we, exp_idx[7], exp_val[16], chk_ctrl}
    localparam int NV = 12;
    localparam logic [52:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,1'b0,8'h05,16'h1234, 1'b1,7'h05,16'h1234, 1'b0}, // R3
        {1'b1,1'b0,1'b0,1'b0,8'h85,16'hBEEF, 1'b1,7'h05,16'hBEEF, 1'b0}, // R3 bit7
        {1'b1,1'b0,1'b1,1'b0,8'h03,16'h1111, 1'b0,7'h00,16'h0000, 1'b0}, // R2 cs
        {1'b1,1'b0,1'b0,1'b1,8'h03,16'h2222, 1'b0,7'h00,16'h0000, 1'b0}, // R2 we
        {1'b0,1'b0,1'b0,1'b0,8'h10,16'hFF34, 1'b0,7'h00,16'h0000, 1'b0}, // R4 even
        {1'b0,1'b0,1'b0,1'b0,8'h11,16'hEE12, 1'b1,7'h08,16'h1234, 1'b0}, // R4 odd
        {1'b0,1'b0,1'b0,1'b0,8'hFE,16'h00AA, 1'b0,7'h00,16'h0000, 1'b0}, // R4 even
        {1'b0,1'b0,1'b0,1'b0,8'hFF,16'h0055, 1'b1,7'h7F,16'h55AA, 1'b0}, // R4 upper
        {1'b1,1'b1,1'b0,1'b0,8'h00,16'hC3C3, 1'b0,7'h00,16'hC3C3, 1'b1}, // R5 word
        {1'b1,1'b1,1'b1,1'b0,8'h00,16'h9999, 1'b0,7'h00,16'hC3C3, 1'b1}, // R2 ctrl
        {1'b0,1'b1,1'b0,1'b0,8'h00,16'h0077, 1'b0,7'h00,16'hC3C3, 1'b1}, // R5 lo
        {1'b0,1'b1,1'b0,1'b0,8'h01,16'h0066, 1'b0,7'h00,16'h6677, 1'b1}  // R5 hi
    };

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        // R1 reset state, host mode
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && strobe_n && !coef_we && ctrl_q == 16'h0, "R1 reset host",
              {busy, strobe_n, coef_we, ctrl_q}, {1'b0, 1'b1, 1'b0, 16'h0});
        self_load = 1'b1;
        #1 check(busy == 1'b1, "R1 busy follows mode", busy, 1);
        self_load = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table of host writes
        for (int i = 0; i < NV; i++) begin
            logic [52:0] v;
            v = VEC[i];
            word_mode = v[52]; reg_sel = v[51]; host_cs_n = v[50]; host_we_n = v[49];
            addr_in = v[48:41]; host_data = v[40:25];
            @(posedge clk);
            @(negedge clk);
            host_cs_n = 1'b1; host_we_n = 1'b1;
            if (v[0])
                check(ctrl_q == v[16:1] && !coef_we, "R5 ctrl target",
                      {coef_we, ctrl_q}, {1'b0, v[16:1]});
            else if (v[24])
                check(coef_we && coef_waddr == v[23:17] && coef_wdata == v[16:1],
                      "R3/R4 store", {coef_we, coef_waddr, coef_wdata}, {1'b1, v[23:1]});
            else
                check(!coef_we, "R2/R4 no store", coef_we, 0);
        end

        // R10 one-cycle pulse
        word_mode = 1'b1; reg_sel = 1'b0; addr_in = 8'h22; host_data = 16'hABCD;
        host_cs_n = 1'b0; host_we_n = 1'b0;
        @(posedge clk); @(negedge clk);
        host_cs_n = 1'b1; host_we_n = 1'b1;
        check(coef_we && coef_wdata == 16'hABCD, "R10 pulse", coef_we, 1);
        @(posedge clk); @(negedge clk);
        check(!coef_we, "R10 single cycle", coef_we, 0);

        // R9 bank read select
        rd_tap = 6'h15; bank_swap = 1'b0;
        #1 check(coef_raddr == 7'h15, "R9 lower bank", coef_raddr, 7'h15);
        bank_swap = 1'b1;
        #1 check(coef_raddr == 7'h55, "R9 upper bank", coef_raddr, 7'h55);

        // self-load: word_mode high and host strobes active are both ignored (R7)
        @(negedge clk);
        rst_n = 1'b0; self_load = 1'b1; rom_on = 1'b1; word_mode = 1'b1;
        host_cs_n = 1'b0; host_we_n = 1'b0; reg_sel = 1'b1; addr_in = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
        begin
            int busy_n = 0, strobe_cnt = 0, we_cnt = 0, bad_data = 0, bad_addr = 0;
            for (int i = 0; i < 300; i++) begin
                #1;
                if (busy) busy_n++;
                if (!strobe_n) begin
                    if (mem_sel != (strobe_cnt >= 256) ||
                        mem_addr != 8'((strobe_cnt >= 256) ? strobe_cnt - 256 : strobe_cnt))
                        bad_addr++;
                    strobe_cnt++;
                end
                if (coef_we) begin
                    logic [7:0] lo, hi;
                    lo = 8'(2 * we_cnt) ^ 8'h5A;
                    hi = 8'(2 * we_cnt + 1) ^ 8'h5A;
                    if (coef_waddr != 7'(we_cnt) || coef_wdata != {hi, lo}) bad_data++;
                    we_cnt++;
                end
                @(negedge clk);
            end
            check(busy_n == 259, "R6 busy length", busy_n, 259);
            check(bad_addr == 0, "R6 address order", bad_addr, 0);
            check(strobe_cnt == 258, "R8 strobe count", strobe_cnt, 258);
            check(we_cnt == 128, "R7 store count", we_cnt, 128);
            check(bad_data == 0, "R7 byte packing", bad_data, 0);
            check(ctrl_q == 16'hA53C, "R6 ctrl loaded last", ctrl_q, 16'hA53C);
            check(!busy && strobe_n, "R8 idle after load", {busy, strobe_n}, 2'b01);
        end
        finish_run();
    end

endmodule